// File: doc/BRIEF.md
# Indirect MDIO PHY Register Access Engine

This block gives a host two registers through which it reaches the management registers of internal PHYs. The host puts write data into the data register and then writes a command word. The command word packs the PHY address, the register number, the opcode bits, a clause-22 mode bit and a start/busy bit. For a valid command the engine runs one clause-22 MDIO frame on a management clock that it divides down from the system clock.

While the frame runs, the busy bit reads back as one. The bit clears by itself when the frame ends. The host polls it, and it gives up after a bounded number of polls. When a read finishes, the captured PHY data sits in the data register.

Two cases have their own handling. A read whose PHY does not answer the turnaround sets a sticky error flag and returns all ones. A malformed command finishes at once and produces no activity on the MDIO pins.

Top module: `phy_ind_access`

## Requirements
- R1: Offset 1 holds the data register. Offset 0 reads back as {busy[15], 0[14], error[13], mode[12], read[11], write[10], phy_addr[9:5], reg_num[4:0]}. Both registers read zero after reset.
- R2: A write command (bit 10 set, bit 11 clear, bit 12 set) sends one frame of 64 bits, MSB first, with the output enable asserted for the whole frame. The frame is 32 ones, then 01, then 01, then the 5-bit PHY address, then the 5-bit register number, then 10, then the 16 bits of the data register.
- R3: A read command (bit 11 set, bit 10 clear, bit 12 set) sends the same preamble, then 01, then 10, then the PHY address and the register number. The output enable is released for the last 18 bit times: turnaround and data.
- R4: MDC has a half period of MDC_HALF_DIV system clocks. MDIO out changes only away from rising MDC edges, and MDIO in is sampled at rising edges. MDC and the output enable stay low while idle.
- R5: Writing a command with bit 15 set while idle starts the command. For a valid command, busy reads 1 from the next cycle until the frame's last falling MDC edge, and then reads 0.
- R6: After a read completes, the data register holds the 16 bits the PHY returned, MSB first.
- R7: While busy, writes to the command register and to the data register are ignored. No second frame starts, and both registers keep their values.
- R8: If MDIO in is not 0 at the second turnaround bit of a read, the data register becomes 16'hFFFF and error bit 13 is set. The error bit stays set until the next accepted command clears it.
- R9: An accepted command with both opcode bits set, neither set, or bit 12 clear is stored with busy 0. It produces no MDC edges and leaves the data register unchanged.
- R10: A command write with bit 15 clear is ignored, and the command register keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register offset: 0 command, 1 data |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO data out |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO data in |

## Verification
The hardest case to reach is a read whose PHY never drives the turnaround zero. That run has to be told apart from a normal read in which the line simply carries ones. The bench's behavioural PHY has a mute switch that leaves the line to a pull-up during the turnaround and the data bits. The bench then checks that the data register reads all ones and that the error flag appears and survives until the next accepted command.

The other hard case is a command or data write that lands mid-frame. The bench aims such writes while busy is still high. It then confirms through the registers and the frame scoreboard that no extra frame went out and that no register value changed.

// File: rtl/phy_ind_pkg.sv
package phy_ind_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_FIRST   = 46;
  localparam int TA_SAMPLE  = 47;
  localparam int DATA_FIRST = 48;

  localparam int CMD_BUSY = 15;
  localparam int CMD_ERR  = 13;
  localparam int CMD_MODE = 12;
  localparam int CMD_RD   = 11;
  localparam int CMD_WR   = 10;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mdio_op_e;
endpackage

// File: rtl/mdc_gen.sv
module mdc_gen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap   = run_i && (cnt_q == CW'(HALF_DIV - 1));
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_mdc_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !mdc_o);
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import phy_ind_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        is_rd_i,
  input  logic [4:0]  phy_i,
  input  logic [4:0]  reg_i,
  input  logic [15:0] wdata_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        mdio_i,
  output logic        run_o,
  output logic        mdio_o,
  output logic        oe_o,
  output logic        done_o,
  output logic [15:0] rdata_o,
  output logic        ta_ok_o
);
  localparam int IW = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] sh_q;
  logic [IW-1:0]         idx_q;
  logic                  run_q, rd_q, ta_ok_q;
  logic [15:0]           rx_q;
  mdio_op_e              op;

  assign op      = is_rd_i ? OP_READ : OP_WRITE;
  assign run_o   = run_q;
  assign mdio_o  = sh_q[FRAME_BITS-1];
  assign oe_o    = run_q && !(rd_q && (idx_q >= IW'(TA_FIRST)));
  assign done_o  = run_q && fall_i && (idx_q == IW'(FRAME_BITS - 1));
  assign rdata_o = rx_q;
  assign ta_ok_o = ta_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      idx_q   <= '0;
      run_q   <= 1'b0;
      rd_q    <= 1'b0;
      ta_ok_q <= 1'b0;
      rx_q    <= '0;
    end else if (start_i && !run_q) begin
      sh_q    <= {32'hFFFF_FFFF, 2'b01, op, phy_i, reg_i,
                  is_rd_i ? 2'b11 : 2'b10, is_rd_i ? 16'hFFFF : wdata_i};
      idx_q   <= '0;
      run_q   <= 1'b1;
      rd_q    <= is_rd_i;
      ta_ok_q <= !is_rd_i;
      rx_q    <= '0;
    end else if (run_q) begin
      if (rise_i && rd_q) begin
        if (idx_q == IW'(TA_SAMPLE)) ta_ok_q <= !mdio_i;
        if (idx_q >= IW'(DATA_FIRST)) rx_q <= {rx_q[14:0], mdio_i};
      end
      if (fall_i) begin
        sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b1};
        idx_q <= idx_q + 1'b1;
        if (idx_q == IW'(FRAME_BITS - 1)) run_q <= 1'b0;
      end
    end
  end

  assert_no_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !done_o) |=> run_q);
endmodule

// File: rtl/phy_ind_access.sv
module phy_ind_access
  import phy_ind_pkg::*;
#(
  parameter int MDC_HALF_DIV = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic        reg_addr_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic [12:0] cmd_q;
  logic        busy_q, err_q;
  logic [15:0] data_q;
  logic        accept, valid, start;
  logic        run, rise, fall, done, ta_ok;
  logic [15:0] rx_data;

  assign accept = reg_wr_i && !reg_addr_i && reg_wdata_i[CMD_BUSY] && !busy_q;
  assign valid  = reg_wdata_i[CMD_MODE] && (reg_wdata_i[CMD_WR] ^ reg_wdata_i[CMD_RD]);
  assign start  = accept && valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      data_q <= '0;
    end else if (busy_q) begin
      if (done) begin
        busy_q <= 1'b0;
        if (cmd_q[CMD_RD]) begin
          data_q <= ta_ok ? rx_data : 16'hFFFF;
          err_q  <= !ta_ok;
        end
      end
    end else if (reg_wr_i) begin
      if (reg_addr_i) begin
        data_q <= reg_wdata_i;
      end else if (accept) begin
        cmd_q  <= reg_wdata_i[12:0];
        err_q  <= 1'b0;
        busy_q <= valid;
      end
    end
  end

  assign reg_rdata_o = reg_addr_i ? data_q : {busy_q, 1'b0, err_q, cmd_q};

  mdc_gen #(.HALF_DIV(MDC_HALF_DIV)) u_mdc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .is_rd_i (reg_wdata_i[CMD_RD]),
    .phy_i   (reg_wdata_i[9:5]),
    .reg_i   (reg_wdata_i[4:0]),
    .wdata_i (data_q),
    .rise_i  (rise),
    .fall_i  (fall),
    .mdio_i  (mdio_i),
    .run_o   (run),
    .mdio_o  (mdio_o),
    .oe_o    (mdio_oe_o),
    .done_o  (done),
    .rdata_o (rx_data),
    .ta_ok_o (ta_ok)
  );

  assert_idle_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (!mdc_o && !mdio_oe_o));
  assert_mdio_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_o) |-> $stable(mdio_o));
  assert_data_locked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> $stable(data_q));
  assert_cmd_locked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> $stable(cmd_q));
  assert_busy_runs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> run);
endmodule

// File: tb/phy_ind_access_bench.sv
module phy_ind_access_bench;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        mdc, mdio_out, mdio_oe, mdio_in;

  always #4 clk = ~clk;

  phy_ind_access #(.MDC_HALF_DIV(DIV)) u_phy_ind_access (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_wr_i    (reg_wr),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .mdc_o       (mdc),
    .mdio_o      (mdio_out),
    .mdio_oe_o   (mdio_oe),
    .mdio_i      (mdio_in)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural PHY
  logic        slv_oe = 1'b0, slv_bit = 1'b1, mute = 1'b0;
  logic [63:0] cap = '0;
  int          edge_n = 0;
  int          rises = 0;
  logic [1:0]  s_op = '0;
  logic [4:0]  s_phy = '0, s_reg = '0;
  bit          oe_bad = 0;
  time         last_rise = 0;
  logic [27:0] exp_q[$];

  assign mdio_in = mdio_oe ? mdio_out : (slv_oe ? slv_bit : 1'b1);

  function automatic logic [15:0] resp(input logic [4:0] p, input logic [4:0] r);
    return {r, p, 6'b101101};
  endfunction

  always @(posedge mdc) begin
    rises++;
    if (edge_n == 10) chk("R4 mdc period", 32'($time - last_rise), 32'(2 * DIV * 8));
    last_rise = $time;
    cap = {cap[62:0], mdio_in};
    if (edge_n >= 46 && s_op == 2'b10 && mdio_oe) oe_bad = 1;
    if (edge_n == 45) begin
      s_op  = cap[11:10];
      s_phy = cap[9:5];
      s_reg = cap[4:0];
    end
    edge_n++;
    if (edge_n == 64) begin
      chk("R2 R3 preamble+start", {cap[63:32]}, 32'hFFFF_FFFF);
      chk("R2 R3 start bits", 32'(cap[31:30]), 32'd1);
      if (s_op == 2'b01) chk("R2 write turnaround", 32'(cap[17:16]), 32'd2);
      chk("R3 oe released", 32'(oe_bad), 32'd0);
      if (exp_q.size() == 0) begin
        chk("R7 unexpected frame", 32'(cap[29:0]), 32'hDEAD);
      end else begin
        chk("R2 R3 frame content", 32'({cap[29:18], cap[15:0]}), 32'(exp_q.pop_front()));
      end
      edge_n = 0;
      oe_bad = 0;
    end
  end

  always @(negedge mdc) begin
    if (edge_n == 47 && s_op == 2'b10 && !mute) begin
      slv_oe  = 1'b1;
      slv_bit = 1'b0;
    end else if (edge_n >= 48 && edge_n <= 63 && s_op == 2'b10 && !mute) begin
      slv_bit = resp(s_phy, s_reg)[15 - (edge_n - 48)];
    end else begin
      slv_oe  = 1'b0;
      slv_bit = 1'b1;
    end
  end

  task automatic host_wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic host_rd(input logic a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic poll_idle();
    logic [15:0] v;
    bit ok = 0;
    for (int i = 0; i < 4000; i++) begin
      host_rd(1'b0, v);
      if (!v[15]) begin ok = 1; break; end
    end
    chk("R5 busy clears", 32'(ok), 32'd1);
  endtask

  task automatic push_exp(input logic [1:0] op, input logic [4:0] p, input logic [4:0] r,
                          input logic [15:0] d);
    exp_q.push_back({op, p, r, d});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int r0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    host_rd(1'b0, v); chk("R1 reset cmd", 32'(v), 32'h0);
    host_rd(1'b1, v); chk("R1 reset data", 32'(v), 32'h0);
    chk("R4 idle mdc/oe", 32'({mdc, mdio_oe}), 32'h0);

    // write frame
    host_wr(1'b1, 16'hA5C3);
    push_exp(2'b01, 5'd3, 5'd5, 16'hA5C3);
    host_wr(1'b0, 16'h9465);
    host_rd(1'b0, v); chk("R5 R1 busy after start", 32'(v), 32'h9465);
    // R7 writes while busy
    host_wr(1'b1, 16'h1234);
    host_wr(1'b0, 16'h9929);
    host_rd(1'b0, v); chk("R7 cmd unchanged while busy", 32'(v), 32'h9465);
    poll_idle();
    host_rd(1'b1, v); chk("R7 data unchanged", 32'(v), 32'hA5C3);
    host_rd(1'b0, v); chk("R5 busy cleared readback", 32'(v), 32'h1465);

    // normal read
    push_exp(2'b10, 5'd7, 5'd2, resp(5'd7, 5'd2));
    host_wr(1'b0, 16'h98E2);
    poll_idle();
    host_rd(1'b1, v); chk("R6 read data", 32'(v), 32'(resp(5'd7, 5'd2)));
    host_rd(1'b0, v); chk("R8 no error on good read", 32'(v), 32'h18E2);

    // missing turnaround
    mute = 1'b1;
    push_exp(2'b10, 5'd1, 5'd31, 16'hFFFF);
    host_wr(1'b0, 16'h983F);
    poll_idle();
    mute = 1'b0;
    host_rd(1'b1, v); chk("R8 all ones", 32'(v), 32'hFFFF);
    host_rd(1'b0, v); chk("R8 error set", 32'(v), 32'h383F);

    // error cleared by next command
    host_wr(1'b1, 16'h0F0F);
    push_exp(2'b01, 5'd2, 5'd17, 16'h0F0F);
    host_wr(1'b0, 16'h9451);
    host_rd(1'b0, v); chk("R8 error cleared", 32'(v), 32'h9451);
    poll_idle();

    // invalid commands
    r0 = rises;
    host_wr(1'b0, 16'h9C21);
    host_rd(1'b0, v); chk("R9 both ops no busy", 32'(v), 32'h1C21);
    repeat (100) @(negedge clk);
    chk("R9 no mdc activity", 32'(rises - r0), 32'd0);
    host_rd(1'b1, v); chk("R9 data unchanged", 32'(v), 32'h0F0F);
    host_wr(1'b0, 16'h8422);
    host_rd(1'b0, v); chk("R9 mode clear no busy", 32'(v), 32'h0422);
    repeat (100) @(negedge clk);
    chk("R9 mode clear no activity", 32'(rises - r0), 32'd0);

    // start bit clear
    host_wr(1'b0, 16'h1465);
    host_rd(1'b0, v); chk("R10 cmd unchanged", 32'(v), 32'h0422);
    repeat (100) @(negedge clk);
    chk("R10 no activity", 32'(rises - r0), 32'd0);

    // read from top address
    push_exp(2'b10, 5'd31, 5'd0, resp(5'd31, 5'd0));
    host_wr(1'b0, 16'h9BE0);
    poll_idle();
    host_rd(1'b1, v); chk("R6 read phy 31", 32'(v), 32'(resp(5'd31, 5'd0)));

    repeat (50) @(negedge clk);
    chk("R2 R3 all frames seen", 32'(exp_q.size()), 32'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule